// File: doc/BRIEF.md
# Cache Array Write Error Injector

This block sits between a cache controller and its tag and data SRAM arrays. On every array write it can deliberately corrupt what is stored, so that the error detection and correction logic downstream can be exercised with known faults. Data bits are flipped through two 32-bit inversion masks, the ECC byte through an 8-bit mask. The ECC byte can also be replaced by the top data byte before its mask is applied. The tag parity bit can be inverted on its own.

Software programs the injector through a small word-wide register port. A control register holds the enables and the ECC mask, and two more registers hold the low and high data masks. The array path is purely combinational. Register contents take effect on the clock edge that writes them, and array cycles with the write strobe low pass through untouched.

Top module: `cache_wr_err_inject`

## Requirements
- R1: After reset all three registers read as zero, and array values pass through unchanged.
- R2: When control bit 16 (tag enable) is set, the tag parity output is the inverse of its input on write cycles. Otherwise it equals its input. The tag bits themselves are never modified.
- R3: When control bit 8 (data enable) is clear, the data and ECC outputs equal their inputs whatever the masks and the mirror bit hold.
- R4: With data enable set, each data bit 31..0 is inverted on write cycles when the matching bit of the low mask register (address 1) is set.
- R5: With data enable set, each data bit 63..32 is inverted on write cycles when bit (n-32) of the high mask register (address 2) is set.
- R6: With data enable set, each ECC bit is inverted on write cycles when the matching bit of control bits 7..0 (the ECC mask) is set.
- R7: When control bit 9 (mirror) and data enable are both set, the ECC byte is replaced by data bits 63..56 of the input, taken before the data mask is applied.
- R8: When mirroring is active, the ECC mask is applied to the mirrored byte.
- R9: Control bits other than 7..0, 8, 9 and 16 read as zero and ignore writes. Address 3 reads as zero and ignores writes. Address 0 is control.
- R10: When the array write strobe is low, all array outputs equal their inputs.
- R11: A register write presented in one cycle does not affect that cycle's array output. It affects array writes from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 control, 1 low mask, 2 high mask) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| arr_wr | input | 1 | Array write strobe |
| in_data | input | 64 | Data word from controller |
| in_ecc | input | 8 | ECC byte from controller |
| in_tag | input | 24 | Tag from controller |
| in_tag_par | input | 1 | Tag parity from controller |
| out_data | output | 64 | Data word to array |
| out_ecc | output | 8 | ECC byte to array |
| out_tag | output | 24 | Tag to array |
| out_tag_par | output | 1 | Tag parity to array |

## Verification
The bound checker checks on every cycle:
- pass-through when the strobe is low or data injection is off;
- that the XOR of data output and data input equals the mask pair during injection;
- that the tag parity flips exactly when tag injection is on;
- that reserved read bits stay zero and a control write lands one edge later.

The mirror ordering can only be shown by the bench's scenarios. In particular, the mirrored byte comes from unmasked data and the ECC mask is applied after mirroring. The same holds for the cycle a register write is still pending, and for the random sweep over all eight enable combinations.

// File: rtl/cache_wr_err_inject.sv
module cache_wr_err_inject #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int TAG_W  = 24,
  parameter int REG_W  = 32,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [AW-1:0]     reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              arr_wr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ECC_W-1:0]  in_ecc,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_tag_par,
  output logic [DATA_W-1:0] out_data,
  output logic [ECC_W-1:0]  out_ecc,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_tag_par
);
  localparam int HALF    = DATA_W / 2;
  localparam int DEN_BIT = ECC_W;
  localparam int MIR_BIT = ECC_W + 1;
  localparam int TEN_BIT = 16;
  localparam logic [AW-1:0] A_CTRL = 0, A_LO = 1, A_HI = 2;

  logic [ECC_W-1:0] ecc_mask;
  logic             den, mir, ten;
  logic [HALF-1:0]  mask_lo, mask_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_mask <= '0;
      den      <= 1'b0;
      mir      <= 1'b0;
      ten      <= 1'b0;
      mask_lo  <= '0;
      mask_hi  <= '0;
    end else if (reg_wen) begin
      case (reg_addr)
        A_CTRL: begin
          ecc_mask <= reg_wdata[ECC_W-1:0];
          den      <= reg_wdata[DEN_BIT];
          mir      <= reg_wdata[MIR_BIT];
          ten      <= reg_wdata[TEN_BIT];
        end
        A_LO:    mask_lo <= reg_wdata[HALF-1:0];
        A_HI:    mask_hi <= reg_wdata[HALF-1:0];
        default: ;
      endcase
    end
  end

  logic [REG_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view          = '0;
    ctrl_view[ECC_W-1:0] = ecc_mask;
    ctrl_view[DEN_BIT] = den;
    ctrl_view[MIR_BIT] = mir;
    ctrl_view[TEN_BIT] = ten;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_view;
      A_LO:    reg_rdata = REG_W'(mask_lo);
      A_HI:    reg_rdata = REG_W'(mask_hi);
      default: reg_rdata = '0;
    endcase
  end

  wire              inj_d   = arr_wr & den;
  wire [ECC_W-1:0]  ecc_src = (inj_d & mir) ? in_data[DATA_W-1 -: ECC_W] : in_ecc;

  assign out_data    = inj_d ? (in_data ^ {mask_hi, mask_lo}) : in_data;
  assign out_ecc     = inj_d ? (ecc_src ^ ecc_mask) : in_ecc;
  assign out_tag     = in_tag;
  assign out_tag_par = in_tag_par ^ (arr_wr & ten);
endmodule

// File: rtl/cache_wr_err_inject_chk.sv
module cache_wr_err_inject_chk #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int TAG_W  = 24,
  parameter int REG_W  = 32,
  parameter int AW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [AW-1:0]     reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              arr_wr,
  input logic [DATA_W-1:0] in_data,
  input logic [ECC_W-1:0]  in_ecc,
  input logic [TAG_W-1:0]  in_tag,
  input logic              in_tag_par,
  input logic [DATA_W-1:0] out_data,
  input logic [ECC_W-1:0]  out_ecc,
  input logic [TAG_W-1:0]  out_tag,
  input logic              out_tag_par,
  input logic              den,
  input logic              ten,
  input logic [DATA_W/2-1:0] mask_lo,
  input logic [DATA_W/2-1:0] mask_hi
);
  localparam int DEN_BIT = ECC_W;
  localparam int MIR_BIT = ECC_W + 1;
  localparam logic [REG_W-1:0] KEEP = (REG_W'(1) << 16) | (REG_W'(1) << MIR_BIT)
                                    | (REG_W'(1) << DEN_BIT) | REG_W'((1 << ECC_W) - 1);

  p_strobe_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_wr |-> (out_data == in_data && out_ecc == in_ecc && out_tag_par == in_tag_par));

  p_data_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !den |-> (out_data == in_data && out_ecc == in_ecc));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && den) |-> ((out_data ^ in_data) == {mask_hi, mask_lo}));

  p_tag_par_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> ((out_tag_par != in_tag_par) == ten));

  p_tag_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_tag == in_tag);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 0) |-> ((reg_rdata & ~KEEP) == '0));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wen) && $past(reg_addr) == 0) |-> (den == $past(reg_wdata[DEN_BIT])));
endmodule

bind cache_wr_err_inject cache_wr_err_inject_chk #(
  .DATA_W(DATA_W), .ECC_W(ECC_W), .TAG_W(TAG_W), .REG_W(REG_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_wr(arr_wr),
  .in_data(in_data), .in_ecc(in_ecc), .in_tag(in_tag), .in_tag_par(in_tag_par),
  .out_data(out_data), .out_ecc(out_ecc), .out_tag(out_tag), .out_tag_par(out_tag_par),
  .den(den), .ten(ten), .mask_lo(mask_lo), .mask_hi(mask_hi)
);

// File: tb/cache_wr_err_inject_tb.sv
`timescale 1ns/1ps
module cache_wr_err_inject_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wen = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        arr_wr = 0;
  logic [63:0] in_data = 0;
  logic [7:0]  in_ecc = 0;
  logic [23:0] in_tag = 0;
  logic        in_tag_par = 0;
  logic [63:0] out_data;
  logic [7:0]  out_ecc;
  logic [23:0] out_tag;
  logic        out_tag_par;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] sh_ctrl = 0, sh_lo = 0, sh_hi = 0;

  always #2 clk = ~clk;

  cache_wr_err_inject u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_data(logic [63:0] d, logic wr);
    return (wr && sh_ctrl[8]) ? d ^ {sh_hi, sh_lo} : d;
  endfunction

  function automatic logic [7:0] exp_ecc(logic [63:0] d, logic [7:0] e, logic wr);
    logic [7:0] src;
    if (!(wr && sh_ctrl[8])) return e;
    src = sh_ctrl[9] ? d[63:56] : e;
    return src ^ sh_ctrl[7:0];
  endfunction

  task automatic reg_write(logic [1:0] a, logic [31:0] v);
    @(negedge clk);
    reg_wen = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wen = 0;
    case (a)
      2'd0: sh_ctrl = v & 32'h0001_03FF;
      2'd1: sh_lo = v;
      2'd2: sh_hi = v;
      default: ;
    endcase
  endtask

  task automatic reg_read(string req, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic arr(string req, logic wr, logic [63:0] d, logic [7:0] e, logic [23:0] t, logic p);
    @(negedge clk);
    arr_wr = wr; in_data = d; in_ecc = e; in_tag = t; in_tag_par = p;
    #1;
    chk(req, out_data, exp_data(d, wr));
    chk(req, 64'(out_ecc), 64'(exp_ecc(d, e, wr)));
    chk("R2", 64'(out_tag), 64'(t));
    chk(req, 64'(out_tag_par), 64'(p ^ (wr & sh_ctrl[16])));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    reg_read("R1", 2'd0, 0);
    reg_read("R1", 2'd1, 0);
    reg_read("R1", 2'd2, 0);
    arr("R1", 1, 64'hFEDC_BA98_7654_3210, 8'h5A, 24'hABCDEF, 1);
    // R9 reserved bits and unused address
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read("R9", 2'd0, 32'h0001_03FF);
    reg_write(2'd3, 32'hFFFF_FFFF);
    reg_read("R9", 2'd3, 0);
    reg_read("R9", 2'd1, 0);
    reg_read("R9", 2'd2, 0);
    reg_write(2'd0, 0);
    // R3 masks loaded but data enable clear
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_write(2'd0, 32'h0000_02FF);
    arr("R3", 1, 64'h0123_4567_89AB_CDEF, 8'h3C, 24'h1, 0);
    // R7 mirror from unmasked data, R8 no ecc mask
    reg_write(2'd0, 32'h0000_0300);
    arr("R7", 1, 64'hA500_0000_0000_0001, 8'h00, 24'h2, 0);
    // R8 mask applied to mirrored byte
    reg_write(2'd0, 32'h0000_030F);
    arr("R8", 1, 64'h6600_0000_0000_0000, 8'hFF, 24'h3, 1);
    // R10 strobe low
    reg_write(2'd0, 32'h0001_03FF);
    arr("R10", 0, 64'h1111_2222_3333_4444, 8'h77, 24'h4, 1);
    // R11 pending write has no effect in its own cycle
    reg_write(2'd0, 0);
    @(negedge clk);
    reg_wen = 1; reg_addr = 0; reg_wdata = 32'h0001_01AA;
    arr_wr = 1; in_data = 64'h0; in_ecc = 8'h0; in_tag_par = 0;
    #1;
    chk("R11", out_data, 64'h0);
    chk("R11", 64'(out_ecc), 64'h0);
    chk("R11", 64'(out_tag_par), 64'h0);
    @(negedge clk);
    reg_wen = 0;
    #1;
    chk("R11", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11", 64'(out_ecc), 64'hAA);
    chk("R11", 64'(out_tag_par), 64'h1);
    sh_ctrl = 32'h0001_01AA;
    // R4 R5 R6 R2: random sweep of enable combinations
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 10; k++) begin
        logic [31:0] cv;
        cv = $urandom & 32'h0000_00FF;
        if (c[0]) cv[8] = 1;
        if (c[1]) cv[9] = 1;
        if (c[2]) cv[16] = 1;
        reg_write(2'd1, $urandom);
        reg_write(2'd2, $urandom);
        reg_write(2'd0, cv | ($urandom & 32'hFFFE_FC00));
        for (int j = 0; j < 3; j++) begin
          arr(c[0] ? (c[1] ? "R8" : "R4") : "R3", 1'b1,
              {$urandom, $urandom}, 8'($urandom), 24'($urandom), 1'($urandom));
        end
        arr("R10", 1'b0, {$urandom, $urandom}, 8'($urandom), 24'($urandom), 1'($urandom));
      end
    end
    // R5 R6 high mask alone and ecc mask alone
    reg_write(2'd1, 0);
    reg_write(2'd2, 32'h8000_0001);
    reg_write(2'd0, 32'h0000_0181);
    arr("R5", 1, 64'h0, 8'h00, 24'h5, 0);
    chk("R5", out_data, 64'h8000_0001_0000_0000);
    chk("R6", 64'(out_ecc), 64'h81);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule